// File: doc/BRIEF.md
# Multimaster Shared Bus Controller

This block joins a set of bus masters to a set of slaves over one shared, synchronous, multiplexed bus. No line of the bus is ever driven by more than one source, because every shared signal is built from AND-OR selection. Each master raises a request. In the next cycle a central arbiter runs a dedicated arbitration cycle and grants the bus to one requester. The granted master's address, direction flag and write data are then steered to the slaves. The addressed slave may stall for any number of cycles. The transfer closes only when that slave raises its acknowledge, or when the address hits no slave.

At elaboration time a parameter chooses the arbitration policy: a rotating (round-robin) order or a static lowest-index-first order. Only one transfer is ever in flight. Pipelined overlap, bursts, bridges and crossbar paths are not part of this block.

Top module: `shared_bus_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `m_gnt`, `m_ack`, `m_err`, `s_sel` and `m_rdata` are all zero.
- R2: A request raised in an idle cycle is seen at the next clock edge, which enters the arbitration cycle. The grant (`m_gnt` bit = master index) becomes visible after the edge that follows, so there are two edges from request to grant.
- R3: With `ROUND_ROBIN=0`, the requesting master with the lowest index wins the arbitration cycle.
- R4: With `ROUND_ROBIN=1`, the master granted most recently has the lowest priority. Priority runs upward from the index after it and wraps around. After reset, master 0 ranks first.
- R5: `s_addr`, `s_we` and `s_wdata` carry only the granted master's fields. They are all zero when no master holds the grant.
- R6: The slave index is the top `SEL_W` bits of the granted address. `s_sel` is one-hot on that slave only while a transfer is active and the index is below `N_SLV`.
- R7: The grant is held unchanged for as long as the selected slave does not acknowledge. An acknowledge from a slave that is not selected is ignored.
- R8: On the edge where the selected slave acknowledges, the grant drops and `m_ack` pulses for one cycle on the granted master's bit. For a write, `s_wdata` holds the master's data throughout.
- R9: In the `m_ack` cycle of a read, `m_rdata` holds the selected slave's data. At all other times it is zero, including when no master is granted and in the acknowledge cycle of a write.
- R10: An address whose slave index is at or above `N_SLV` selects no slave. It is acknowledged internally on the first transfer edge, with `m_err` set on the same bit as `m_ack` and read data of zero.
- R11: At most one grant bit and at most one select bit are ever set.
- R12: After a transfer ends, the bus returns to idle. A request still pending is granted two edges after the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | N_MST | Bus request, one bit per master |
| m_addr | input | N_MST*AW | Addresses, master i in bits [i*AW +: AW] |
| m_we | input | N_MST | Direction per master, 1 = write |
| m_wdata | input | N_MST*DW | Write data, master i in bits [i*DW +: DW] |
| m_gnt | output | N_MST | One-hot grant |
| m_ack | output | N_MST | One-cycle completion pulse for the granted master |
| m_err | output | N_MST | Set together with m_ack on an unmapped address |
| m_rdata | output | DW | Read data, valid in the m_ack cycle, otherwise zero |
| s_sel | output | N_SLV | One-hot slave select |
| s_addr | output | AW | Shared address to slaves |
| s_we | output | 1 | Shared direction to slaves |
| s_wdata | output | DW | Shared write data to slaves |
| s_rdata | input | N_SLV*DW | Read data, slave j in bits [j*DW +: DW] |
| s_ack | input | N_SLV | Slave acknowledge |

## Verification
The hardest case to reach from the ports is the split between the two policies under contention. Both the rotating and the static arbiter grant master 0 from reset, so their difference shows only once the rotation pointer has moved. The bench drives two instances, one per policy, from the same inputs. It first finishes a transfer by master 0 and then raises two requests together, so that the two instances must grant different masters. During slave stalls it also asserts the acknowledge of the slave that is not selected, to show that the stray acknowledge does not end the transfer.

// File: rtl/bus_pkg.sv
package bus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ARB  = 2'd1,
    PH_XFER = 2'd2
  } bus_phase_e;
endpackage

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int N_MST       = 3,
  parameter int ROUND_ROBIN = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MST-1:0] req,
  input  logic             arb_en,
  output logic [N_MST-1:0] win,
  output logic             any
);
  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1;

  assign any = |req;

  generate
    if (ROUND_ROBIN != 0) begin : g_rr
      logic [IW-1:0] last_q;
      logic [IW-1:0] win_idx;

      always_comb begin
        win     = '0;
        win_idx = last_q;
        for (int k = 1; k <= N_MST; k++) begin
          int j;
          j = int'(last_q) + k;
          if (j >= N_MST) j = j - N_MST;
          if (win == '0 && req[j]) begin
            win[j]  = 1'b1;
            win_idx = IW'(j);
          end
        end
      end

      always_ff @(posedge clk) begin
        if (rst) last_q <= IW'(N_MST - 1);
        else if (arb_en && any) last_q <= win_idx;
      end
    end else begin : g_fixed
      always_comb begin
        win = '0;
        for (int k = 0; k < N_MST; k++)
          if (win == '0 && req[k]) win[k] = 1'b1;
      end
    end
  endgenerate

  // the winner is a single requesting master (R3, R4)
  assert_win_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (arb_en && any) |-> ($onehot(win) && ((win & ~req) == '0)));
endmodule

// File: rtl/bus_decoder.sv
module bus_decoder #(
  parameter int AW    = 8,
  parameter int SEL_W = 2,
  parameter int N_SLV = 2
) (
  input  logic [AW-1:0]    addr,
  input  logic             en,
  output logic [N_SLV-1:0] sel,
  output logic             miss
);
  logic [SEL_W-1:0] idx;
  assign idx = addr[AW-1 -: SEL_W];

  always_comb begin
    sel = '0;
    for (int s = 0; s < N_SLV; s++)
      sel[s] = en && (int'(idx) == s);
    miss = en && (int'(idx) >= N_SLV);
  end
endmodule

// File: rtl/bus_mux.sv
module bus_mux #(
  parameter int N_MST = 3,
  parameter int N_SLV = 2,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic [N_MST-1:0]    gnt,
  input  logic [N_MST*AW-1:0] m_addr,
  input  logic [N_MST-1:0]    m_we,
  input  logic [N_MST*DW-1:0] m_wdata,
  input  logic [N_SLV-1:0]    sel,
  input  logic [N_SLV*DW-1:0] s_rdata,
  input  logic [N_SLV-1:0]    s_ack,
  output logic [AW-1:0]       bus_addr,
  output logic                bus_we,
  output logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       sel_rdata,
  output logic                sel_ack
);
  always_comb begin
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    for (int i = 0; i < N_MST; i++) begin
      bus_addr  = bus_addr  | (m_addr[i*AW +: AW]  & {AW{gnt[i]}});
      bus_wdata = bus_wdata | (m_wdata[i*DW +: DW] & {DW{gnt[i]}});
      bus_we    = bus_we    | (m_we[i] & gnt[i]);
    end
  end

  always_comb begin
    sel_rdata = '0;
    for (int s = 0; s < N_SLV; s++)
      sel_rdata = sel_rdata | (s_rdata[s*DW +: DW] & {DW{sel[s]}});
    sel_ack = |(s_ack & sel);
  end
endmodule

// File: rtl/shared_bus_ctrl.sv
module shared_bus_ctrl
  import bus_pkg::*;
#(
  parameter int N_MST       = 3,
  parameter int N_SLV       = 2,
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int SEL_W       = 2,
  parameter int ROUND_ROBIN = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_MST-1:0]    m_req,
  input  logic [N_MST*AW-1:0] m_addr,
  input  logic [N_MST-1:0]    m_we,
  input  logic [N_MST*DW-1:0] m_wdata,
  output logic [N_MST-1:0]    m_gnt,
  output logic [N_MST-1:0]    m_ack,
  output logic [N_MST-1:0]    m_err,
  output logic [DW-1:0]       m_rdata,
  output logic [N_SLV-1:0]    s_sel,
  output logic [AW-1:0]       s_addr,
  output logic                s_we,
  output logic [DW-1:0]       s_wdata,
  input  logic [N_SLV*DW-1:0] s_rdata,
  input  logic [N_SLV-1:0]    s_ack
);
  bus_phase_e          ph_q;
  logic [N_MST-1:0]    gnt_q, ack_q, err_q;
  logic [DW-1:0]       rdata_q;
  logic [N_MST-1:0]    win;
  logic                any_req, miss, slv_ack, done;
  logic [DW-1:0]       sel_rdata;

  bus_arbiter #(.N_MST(N_MST), .ROUND_ROBIN(ROUND_ROBIN)) u_arb (
    .clk(clk), .rst(rst), .req(m_req), .arb_en(ph_q == PH_ARB),
    .win(win), .any(any_req));

  bus_mux #(.N_MST(N_MST), .N_SLV(N_SLV), .AW(AW), .DW(DW)) u_mux (
    .gnt(gnt_q), .m_addr(m_addr), .m_we(m_we), .m_wdata(m_wdata),
    .sel(s_sel), .s_rdata(s_rdata), .s_ack(s_ack),
    .bus_addr(s_addr), .bus_we(s_we), .bus_wdata(s_wdata),
    .sel_rdata(sel_rdata), .sel_ack(slv_ack));

  bus_decoder #(.AW(AW), .SEL_W(SEL_W), .N_SLV(N_SLV)) u_dec (
    .addr(s_addr), .en(ph_q == PH_XFER), .sel(s_sel), .miss(miss));

  assign done = (ph_q == PH_XFER) && (slv_ack || miss);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      gnt_q   <= '0;
      ack_q   <= '0;
      err_q   <= '0;
      rdata_q <= '0;
    end else begin
      ack_q   <= '0;
      err_q   <= '0;
      rdata_q <= '0;
      unique case (ph_q)
        PH_IDLE: if (any_req) ph_q <= PH_ARB;
        PH_ARB: begin
          if (any_req) begin
            gnt_q <= win;
            ph_q  <= PH_XFER;
          end else begin
            ph_q  <= PH_IDLE;
          end
        end
        PH_XFER: begin
          if (done) begin
            ph_q    <= PH_IDLE;
            gnt_q   <= '0;
            ack_q   <= gnt_q;
            err_q   <= miss ? gnt_q : '0;
            rdata_q <= (!s_we && !miss) ? sel_rdata : '0;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign m_gnt   = gnt_q;
  assign m_ack   = ack_q;
  assign m_err   = err_q;
  assign m_rdata = rdata_q;

  assert_one_grant_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_gnt) && $onehot0(s_sel));

  assert_arb_grants_R2: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_ARB && m_req != '0) |=> (m_gnt != '0));

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (s_sel != '0 && (s_ack & s_sel) == '0) |=> ($stable(m_gnt) && m_ack == '0));

  assert_ack_closes_R8: assert property (@(posedge clk) disable iff (rst)
    (m_ack != '0) |-> ($past(m_gnt) == m_ack && m_gnt == '0));

  assert_rdata_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (m_ack == '0) |-> (m_rdata == '0));

  assert_unmapped_err_R10: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_XFER && s_sel == '0) |=> (m_err == m_ack && m_ack != '0));

  assert_bus_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (m_gnt == '0) |-> (s_addr == '0 && !s_we && s_wdata == '0));
endmodule

// File: tb/shared_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module shared_bus_ctrl_tb_top;
  localparam int N_MST = 3, N_SLV = 2, AW = 8, DW = 16, SEL_W = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [N_MST-1:0]    m_req = '0, m_we = '0;
  logic [N_MST*AW-1:0] m_addr = '0;
  logic [N_MST*DW-1:0] m_wdata = '0;
  logic [N_SLV*DW-1:0] s_rdata = '0;
  logic [N_SLV-1:0]    s_ack = '0;
  logic [N_MST-1:0]    m_gnt, m_ack, m_err, fp_gnt, fp_ack, fp_err;
  logic [DW-1:0]       m_rdata, s_wdata, fp_rdata, fp_wdata;
  logic [N_SLV-1:0]    s_sel, fp_sel;
  logic [AW-1:0]       s_addr, fp_addr;
  logic                s_we, fp_we;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  shared_bus_ctrl #(.N_MST(N_MST), .N_SLV(N_SLV), .AW(AW), .DW(DW),
                    .SEL_W(SEL_W), .ROUND_ROBIN(1)) dut_i (
    .clk(clk), .rst(rst), .m_req(m_req), .m_addr(m_addr), .m_we(m_we),
    .m_wdata(m_wdata), .m_gnt(m_gnt), .m_ack(m_ack), .m_err(m_err),
    .m_rdata(m_rdata), .s_sel(s_sel), .s_addr(s_addr), .s_we(s_we),
    .s_wdata(s_wdata), .s_rdata(s_rdata), .s_ack(s_ack));

  shared_bus_ctrl #(.N_MST(N_MST), .N_SLV(N_SLV), .AW(AW), .DW(DW),
                    .SEL_W(SEL_W), .ROUND_ROBIN(0)) dut_fp (
    .clk(clk), .rst(rst), .m_req(m_req), .m_addr(m_addr), .m_we(m_we),
    .m_wdata(m_wdata), .m_gnt(fp_gnt), .m_ack(fp_ack), .m_err(fp_err),
    .m_rdata(fp_rdata), .s_sel(fp_sel), .s_addr(fp_addr), .s_we(fp_we),
    .s_wdata(fp_wdata), .s_rdata(s_rdata), .s_ack(s_ack));

  // {master[2], we[1], addr[8], wdata[16], stall[4], slave rdata[16]}
  localparam logic [46:0] VEC [6] = '{
    {2'd0, 1'b1, 8'h12, 16'hA5A5, 4'd0, 16'h0000},
    {2'd1, 1'b0, 8'h47, 16'h0000, 4'd3, 16'h1234},
    {2'd2, 1'b1, 8'h55, 16'h0F0F, 4'd2, 16'h0000},
    {2'd1, 1'b0, 8'h9C, 16'h0000, 4'd1, 16'h4321},
    {2'd0, 1'b0, 8'h3F, 16'h0000, 4'd5, 16'hBEEF},
    {2'd2, 1'b1, 8'hC1, 16'h7777, 4'd0, 16'h0000}
  };

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_txn(input int m, input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input int stall,
                        input logic [DW-1:0] rd);
    int idx;
    bit unm;
    logic [N_MST-1:0] mb;
    idx = int'(a[AW-1 -: SEL_W]);
    unm = (idx >= N_SLV);
    mb  = N_MST'(1) << m;
    m_addr  = {N_MST{8'hFF}};
    m_wdata = {N_MST{16'hDEAD}};
    m_we    = ~mb;
    m_addr[m*AW +: AW]  = a;
    m_wdata[m*DW +: DW] = wd;
    m_we[m]  = we;
    m_req    = mb;
    s_rdata  = {N_SLV{16'h7777}};
    tick();
    chk(m_gnt == '0, "R2 no grant in arbitration cycle", 32'(m_gnt), 0);
    tick();
    chk(m_gnt == mb, "R2 grant after arbitration", 32'(m_gnt), 32'(mb));
    chk(s_addr == a && s_we == we, "R5 granted address/direction",
        {s_we, s_addr}, {we, a});
    chk(s_wdata == wd, "R8 write data steered", 32'(s_wdata), 32'(wd));
    chk(s_sel == (unm ? '0 : N_SLV'(1) << idx), "R6 slave select",
        32'(s_sel), unm ? 0 : (1 << idx));
    if (!unm) begin
      for (int c = 0; c < stall; c++) begin
        s_ack = '0;
        s_ack[N_SLV-1-idx] = 1'b1;
        tick();
        chk(m_ack == '0 && m_gnt == mb, "R7 grant held during stall",
            {m_ack, m_gnt}, {3'b000, mb});
      end
      s_ack = '0;
      s_ack[idx] = 1'b1;
      s_rdata[idx*DW +: DW] = rd;
      tick();
      s_ack = '0;
    end else begin
      tick();
    end
    chk(m_ack == mb && m_gnt == '0, "R8 ack pulse closes transfer",
        {m_ack, m_gnt}, {mb, 3'b000});
    chk(m_err == (unm ? mb : '0), "R10 error flag", 32'(m_err), unm ? 32'(mb) : 0);
    chk(m_rdata == ((we || unm) ? '0 : rd), "R9 read data in ack cycle",
        32'(m_rdata), (we || unm) ? 0 : 32'(rd));
    m_req = '0;
    tick();
    chk(m_ack == '0 && m_rdata == '0, "R9 read data zero after ack",
        {m_ack, m_rdata}, 0);
    chk(s_addr == '0 && s_wdata == '0 && !s_we, "R5 bus quiet without grant",
        {s_we, s_addr, s_wdata}, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_req = 3'b111;
    repeat (3) tick();
    chk(m_gnt == '0 && m_ack == '0 && m_err == '0 && s_sel == '0 && m_rdata == '0,
        "R1 reset outputs", {m_gnt, m_ack, m_err, s_sel}, 0);
    m_req = '0;
    rst = 1'b0;
    tick();
    chk(m_gnt == '0 && m_ack == '0 && m_rdata == '0, "R1 first cycle after reset",
        {m_gnt, m_ack}, 0);

    for (int i = 0; i < 6; i++) begin
      logic [46:0] v;
      v = VEC[i];
      do_txn(int'(v[46:45]), v[44], v[43:36], v[35:20], int'(v[19:16]), v[15:0]);
    end

    // master 0 last: rotation now starts at master 1
    do_txn(0, 1'b1, 8'h10, 16'h1111, 0, 16'h0);
    m_addr = {8'h20, 8'h33, 8'h10};
    m_we   = 3'b111;
    m_req  = 3'b101;
    tick();
    tick();
    chk(m_gnt == 3'b100, "R4 rotating grant skips last winner", 32'(m_gnt), 32'h4);
    chk(fp_gnt == 3'b001, "R3 static grant to lowest index", 32'(fp_gnt), 32'h1);
    chk(m_gnt != '0 && fp_gnt != '0 && $countones({m_gnt, fp_gnt}) == 2,
        "R11 single grant per bus", {m_gnt, fp_gnt}, 32'h21);
    s_ack = 2'b01;
    tick();
    s_ack = '0;
    chk(m_ack == 3'b100 && fp_ack == 3'b001, "R8 ack per policy",
        {m_ack, fp_ack}, 32'h21);
    m_req = '0;
    tick();
    m_req = 3'b101;
    tick();
    tick();
    chk(m_gnt == 3'b001, "R4 rotation wraps to master 0", 32'(m_gnt), 32'h1);
    s_ack = 2'b01;
    tick();
    s_ack = '0;
    m_req = 3'b100;
    tick();
    chk(m_gnt == '0, "R12 idle cycle before re-arbitration", 32'(m_gnt), 0);
    tick();
    chk(m_gnt == 3'b100 && fp_gnt == 3'b100, "R12 pending request granted",
        {m_gnt, fp_gnt}, 32'h24);
    s_ack = 2'b01;
    tick();
    s_ack = '0;
    m_req = '0;
    tick();
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule